// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Tracker

This block holds the per-CPU bookkeeping that sits between an interrupt arbiter and the processors it serves. When a CPU reads its acknowledge register, the arbiter's best pending ID is offered to this block. The block accepts the ID only if it is a real source and more urgent than what the CPU is already running. An accepted ID becomes the running interrupt. The interrupted one is remembered in a per-CPU link table, so nested preemption forms a chain, and the block emits a request to clear the source's pending state.

When a CPU writes an end-of-interrupt value, the block either pops the running interrupt, which restores the running ID and priority from the link table, or it removes an older entry from the middle of the chain. The removal walks the chain one link per clock while `busy` is high. At completion, a level-sensitive source that is still asserted, enabled and routed to the completing CPU is requested pending again.

Lower priority values are more urgent. A running priority of 0x100 means idle, and ID 1023 means "no interrupt".

Top module: `irq_ack_tracker`

## Requirements
- R1: An acknowledge returns ID 1023 and changes no state when the offered ID is 1023 or any value not below the ID count, or when its priority is greater than or equal to the CPU's running priority. No pending-clear request is issued in that case.
- R2: A successful acknowledge returns the offered ID one cycle after the request. That ID becomes the CPU's running ID, and its priority (zero-extended to 9 bits) becomes the running priority.
- R3: On a successful acknowledge the pending-clear request carries the ID and a CPU mask (bit n = CPU n). The mask is all ones when the source's model bit is 1, and only the acknowledging CPU's bit when the model bit is 0.
- R4: A running ID of 1023 always comes with running priority 0x100; this is the reset state of every CPU. An end-of-interrupt that arrives while the CPU runs ID 1023 has no effect and produces no re-pend request.
- R5: At an accepted end-of-interrupt, a re-pend request for the completing CPU only (mask bit n = CPU n) is issued when the named source is level-sensitive (edge bit 0), enabled, its level input is high, and its target bit for that CPU is set. Otherwise no re-pend request is issued.
- R6: Completing the running ID makes the link stored at acknowledge time the new running ID, with that ID's priority, or 0x100 when the link is 1023.
- R7: Completing an ID other than the running one starts a chain walk from the running ID, one link per clock, with `busy` high. The predecessor of the named entry takes over the named entry's link, and the running ID stays unchanged.
- R8: Only bits [9:0] of the end-of-interrupt data name the ID; the upper bits are ignored.
- R9: While `busy` is high, acknowledge and end-of-interrupt requests are ignored. When both requests arrive in the same idle cycle, the acknowledge is served and the end-of-interrupt is dropped.
- R10: All link entries reset to 1023, so the first interrupt acknowledged after reset returns the CPU to idle when completed.
- R11: A chain walk that reaches link 1023 without finding the named ID ends with the chain and the running state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prio | input | N_IDS*8 | Priority of each ID, ID n in bits [8n+7:8n] |
| cfg_enable | input | N_IDS | Source enable per ID |
| cfg_edge | input | N_IDS | 1 = edge-sensitive, 0 = level-sensitive |
| cfg_model | input | N_IDS | 1 = clear pending on all CPUs at acknowledge |
| cfg_target | input | N_IDS*N_CPU | Target CPU bits, ID n in bits [n*N_CPU +: N_CPU] |
| src_level | input | N_IDS | Current level of each source |
| ack_req | input | 1 | Acknowledge read strobe |
| ack_cpu | input | 1 | CPU performing the acknowledge |
| pend_id | input | 10 | Arbiter's pending ID for that CPU |
| eoi_req | input | 1 | End-of-interrupt write strobe |
| eoi_cpu | input | 1 | CPU performing the completion |
| eoi_data | input | 32 | Completion write data |
| ack_rsp_valid | output | 1 | Acknowledge response valid |
| ack_rsp_id | output | 10 | Acknowledged ID or 1023 |
| pclr_valid | output | 1 | Pending-clear request |
| pclr_id | output | 10 | ID to clear |
| pclr_mask | output | N_CPU | CPUs to clear |
| pset_valid | output | 1 | Re-pend request |
| pset_id | output | 10 | ID to re-pend |
| pset_mask | output | N_CPU | CPU to re-pend |
| run_id | output | N_CPU*10 | Running ID per CPU |
| run_prio | output | N_CPU*9 | Running priority per CPU |
| busy | output | 1 | Chain walk in progress |

## Verification
The hardest state to reach is a middle-of-chain removal. It needs three nested acknowledges with strictly falling priority values on one CPU, then completion of the oldest entry, which forces a two-step walk. The stimulus builds that nesting, completes the bottom entry, and watches `busy` on each cycle of the walk. An acknowledge is injected mid-walk to show it is dropped. The remaining two entries are then completed in order to show the splice: the second pop must land on idle instead of the removed ID.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
    parameter int ID_W   = 10;
    parameter int PRIO_W = 8;

    typedef logic [ID_W-1:0]   id_t;
    typedef logic [PRIO_W:0]   rprio_t;

    localparam id_t    ID_NONE   = '1;
    localparam rprio_t PRIO_IDLE = rprio_t'(1 << PRIO_W);
endpackage

// File: rtl/irq_prio_lookup.sv
module irq_prio_lookup
    import irq_trk_pkg::*;
#(
    parameter int N_IDS = 64
) (
    input  logic [N_IDS*PRIO_W-1:0] prio_tbl,
    input  id_t                     id,
    output rprio_t                  prio
);
    localparam int  IDX_W    = $clog2(N_IDS);
    localparam id_t ID_LIMIT = id_t'(N_IDS);

    logic [PRIO_W-1:0] entry [N_IDS];

    for (genvar i = 0; i < N_IDS; i++) begin : g_unpack
        assign entry[i] = prio_tbl[i*PRIO_W +: PRIO_W];
    end

    always_comb begin
        if (id < ID_LIMIT) prio = {1'b0, entry[id[IDX_W-1:0]]};
        else               prio = PRIO_IDLE;
    end
endmodule

// File: rtl/irq_repend_eval.sv
module irq_repend_eval
    import irq_trk_pkg::*;
#(
    parameter int N_IDS = 64,
    parameter int N_CPU = 2
) (
    input  logic [N_IDS-1:0]       enable,
    input  logic [N_IDS-1:0]       edge_mode,
    input  logic [N_IDS-1:0]       level,
    input  logic [N_IDS*N_CPU-1:0] target,
    input  id_t                    id,
    input  logic [$clog2(N_CPU)-1:0] cpu,
    output logic                   hit
);
    localparam int  IDX_W    = $clog2(N_IDS);
    localparam id_t ID_LIMIT = id_t'(N_IDS);

    logic [IDX_W-1:0] idx;
    logic [N_CPU-1:0] tgt_row;

    always_comb begin
        idx     = id[IDX_W-1:0];
        tgt_row = target[idx*N_CPU +: N_CPU];
        hit     = (id < ID_LIMIT) && !edge_mode[idx] && enable[idx]
                  && level[idx] && tgt_row[cpu];
    end
endmodule

// File: rtl/irq_ack_tracker.sv
module irq_ack_tracker
    import irq_trk_pkg::*;
#(
    parameter int N_IDS  = 64,
    parameter int N_CPU  = 2,
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_IDS*PRIO_W-1:0]     cfg_prio,
    input  logic [N_IDS-1:0]            cfg_enable,
    input  logic [N_IDS-1:0]            cfg_edge,
    input  logic [N_IDS-1:0]            cfg_model,
    input  logic [N_IDS*N_CPU-1:0]      cfg_target,
    input  logic [N_IDS-1:0]            src_level,
    input  logic                        ack_req,
    input  logic [$clog2(N_CPU)-1:0]    ack_cpu,
    input  logic [ID_W-1:0]             pend_id,
    input  logic                        eoi_req,
    input  logic [$clog2(N_CPU)-1:0]    eoi_cpu,
    input  logic [DATA_W-1:0]           eoi_data,
    output logic                        ack_rsp_valid,
    output logic [ID_W-1:0]             ack_rsp_id,
    output logic                        pclr_valid,
    output logic [ID_W-1:0]             pclr_id,
    output logic [N_CPU-1:0]            pclr_mask,
    output logic                        pset_valid,
    output logic [ID_W-1:0]             pset_id,
    output logic [N_CPU-1:0]            pset_mask,
    output logic [N_CPU*ID_W-1:0]       run_id,
    output logic [N_CPU*(PRIO_W+1)-1:0] run_prio,
    output logic                        busy
);
    localparam int  IDX_W    = $clog2(N_IDS);
    localparam int  CPU_W    = $clog2(N_CPU);
    localparam id_t ID_LIMIT = id_t'(N_IDS);

    typedef struct packed {
        logic [N_CPU-1:0][N_IDS-1:0][ID_W-1:0] link;
        logic [N_CPU-1:0][ID_W-1:0]            run_id;
        logic [N_CPU-1:0][PRIO_W:0]            run_pr;
        logic                                  busy;
        logic [CPU_W-1:0]                      walk_cpu;
        id_t                                   walk_cur;
        id_t                                   walk_tgt;
        logic                                  ack_v;
        id_t                                   ack_id;
        logic                                  pclr_v;
        id_t                                   pclr_id;
        logic [N_CPU-1:0]                      pclr_m;
        logic                                  pset_v;
        id_t                                   pset_id;
        logic [N_CPU-1:0]                      pset_m;
    } trk_t;

    trk_t st_d, st_q;

    id_t    eoi_id;
    id_t    cur_run;
    id_t    restore_id;
    rprio_t pend_pr;
    rprio_t restore_pr;
    logic   repend_hit;
    logic   unused_data_hi;

    assign eoi_id         = eoi_data[ID_W-1:0];
    assign unused_data_hi = ^eoi_data[DATA_W-1:ID_W];
    assign cur_run        = st_q.run_id[eoi_cpu];
    assign restore_id     = st_q.link[eoi_cpu][cur_run[IDX_W-1:0]];

    irq_prio_lookup #(.N_IDS(N_IDS)) u_pend_pr (
        .prio_tbl (cfg_prio),
        .id       (pend_id),
        .prio     (pend_pr)
    );

    irq_prio_lookup #(.N_IDS(N_IDS)) u_restore_pr (
        .prio_tbl (cfg_prio),
        .id       (restore_id),
        .prio     (restore_pr)
    );

    irq_repend_eval #(.N_IDS(N_IDS), .N_CPU(N_CPU)) u_repend (
        .enable    (cfg_enable),
        .edge_mode (cfg_edge),
        .level     (src_level),
        .target    (cfg_target),
        .id        (eoi_id),
        .cpu       (eoi_cpu),
        .hit       (repend_hit)
    );

    always_comb begin
        id_t              nxt;
        logic [IDX_W-1:0] pidx;
        st_d        = st_q;
        st_d.ack_v  = 1'b0;
        st_d.pclr_v = 1'b0;
        st_d.pset_v = 1'b0;
        nxt         = st_q.link[st_q.walk_cpu][st_q.walk_cur[IDX_W-1:0]];
        pidx        = pend_id[IDX_W-1:0];

        if (st_q.busy) begin
            if (nxt == ID_NONE) begin
                st_d.busy = 1'b0;
            end else if (nxt == st_q.walk_tgt) begin
                st_d.link[st_q.walk_cpu][st_q.walk_cur[IDX_W-1:0]] =
                    st_q.link[st_q.walk_cpu][st_q.walk_tgt[IDX_W-1:0]];
                st_d.busy = 1'b0;
            end else begin
                st_d.walk_cur = nxt;
            end
        end else if (ack_req) begin
            st_d.ack_v  = 1'b1;
            st_d.ack_id = ID_NONE;
            if (pend_id < ID_LIMIT && pend_pr < st_q.run_pr[ack_cpu]) begin
                st_d.ack_id              = pend_id;
                st_d.link[ack_cpu][pidx] = st_q.run_id[ack_cpu];
                st_d.run_id[ack_cpu]     = pend_id;
                st_d.run_pr[ack_cpu]     = pend_pr;
                st_d.pclr_v              = 1'b1;
                st_d.pclr_id             = pend_id;
                st_d.pclr_m              = cfg_model[pidx] ? '1
                                           : N_CPU'(1) << ack_cpu;
            end
        end else if (eoi_req) begin
            if (cur_run != ID_NONE && eoi_id < ID_LIMIT) begin
                if (repend_hit) begin
                    st_d.pset_v  = 1'b1;
                    st_d.pset_id = eoi_id;
                    st_d.pset_m  = N_CPU'(1) << eoi_cpu;
                end
                if (eoi_id == cur_run) begin
                    st_d.run_id[eoi_cpu] = restore_id;
                    st_d.run_pr[eoi_cpu] = restore_pr;
                end else begin
                    st_d.busy     = 1'b1;
                    st_d.walk_cpu = eoi_cpu;
                    st_d.walk_cur = cur_run;
                    st_d.walk_tgt = eoi_id;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.link    <= '1;
            st_q.run_id  <= '1;
            st_q.ack_id  <= ID_NONE;
            for (int c = 0; c < N_CPU; c++) st_q.run_pr[c] <= PRIO_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_rsp_valid = st_q.ack_v;
    assign ack_rsp_id    = st_q.ack_id;
    assign pclr_valid    = st_q.pclr_v;
    assign pclr_id       = st_q.pclr_id;
    assign pclr_mask     = st_q.pclr_m;
    assign pset_valid    = st_q.pset_v;
    assign pset_id       = st_q.pset_id;
    assign pset_mask     = st_q.pset_m;
    assign run_id        = st_q.run_id;
    assign run_prio      = st_q.run_pr;
    assign busy          = st_q.busy;

    // R1
    refused_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rsp_valid && ack_rsp_id == ID_NONE) |-> !pclr_valid);

    // R2
    clear_matches_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pclr_valid |-> (ack_rsp_valid && pclr_id == ack_rsp_id));

    // R5
    repend_after_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pset_valid |-> ($past(eoi_req) && $onehot0(pset_mask)));

    // R7
    walk_from_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(eoi_req));

    // R9
    busy_blocks_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !ack_rsp_valid);

    for (genvar c = 0; c < N_CPU; c++) begin : g_idle_chk
        // R4
        idle_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.run_id[c] == ID_NONE) |-> (st_q.run_pr[c] == PRIO_IDLE));
    end
endmodule

// File: tb/irq_ack_tracker_tb.sv
module irq_ack_tracker_tb;
    localparam int N_IDS = 64;
    localparam int N_CPU = 2;

    logic clk = 0;
    logic rst_n = 0;
    logic [N_IDS*8-1:0] cfg_prio;
    logic [N_IDS-1:0]   cfg_enable, cfg_edge, cfg_model, src_level;
    logic [N_IDS*N_CPU-1:0] cfg_target;
    logic ack_req = 0, eoi_req = 0;
    logic ack_cpu = 0, eoi_cpu = 0;
    logic [9:0]  pend_id = 10'h3FF;
    logic [31:0] eoi_data = 0;
    logic ack_rsp_valid, pclr_valid, pset_valid, busy;
    logic [9:0] ack_rsp_id, pclr_id, pset_id;
    logic [1:0] pclr_mask, pset_mask;
    logic [19:0] run_id;
    logic [17:0] run_prio;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    irq_ack_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_prio(cfg_prio), .cfg_enable(cfg_enable),
        .cfg_edge(cfg_edge), .cfg_model(cfg_model), .cfg_target(cfg_target),
        .src_level(src_level), .ack_req(ack_req), .ack_cpu(ack_cpu),
        .pend_id(pend_id), .eoi_req(eoi_req), .eoi_cpu(eoi_cpu),
        .eoi_data(eoi_data), .ack_rsp_valid(ack_rsp_valid),
        .ack_rsp_id(ack_rsp_id), .pclr_valid(pclr_valid), .pclr_id(pclr_id),
        .pclr_mask(pclr_mask), .pset_valid(pset_valid), .pset_id(pset_id),
        .pset_mask(pset_mask), .run_id(run_id), .run_prio(run_prio), .busy(busy)
    );

    function automatic int prio_of(int id);
        return 200 - 3 * id;
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst_n = 0; ack_req = 0; eoi_req = 0;
        #10;
        rst_n = 1;
        step();
    endtask

    task automatic do_ack(input logic cpu, input int id);
        ack_req = 1; ack_cpu = cpu; pend_id = 10'(id);
        step();
        ack_req = 0;
    endtask

    task automatic do_eoi(input logic cpu, input logic [31:0] data);
        eoi_req = 1; eoi_cpu = cpu; eoi_data = data;
        step();
        eoi_req = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy; i++) step();
    endtask

    function automatic int rid(input logic cpu);
        return int'(run_id[cpu*10 +: 10]);
    endfunction

    function automatic int rpr(input logic cpu);
        return int'(run_prio[cpu*9 +: 9]);
    endfunction

    typedef struct packed {
        logic        is_eoi;
        logic        cpu;
        logic [31:0] data;
        logic [9:0]  rsp;
        logic [9:0]  run;
        logic [8:0]  pr;
    } vec_t;

    localparam vec_t VEC [13] = '{
        '{1'b0, 1'b0, 32'd10,         10'd10,   10'd10,   9'd170},
        '{1'b0, 1'b0, 32'd5,          10'd1023, 10'd10,   9'd170},
        '{1'b0, 1'b0, 32'd20,         10'd20,   10'd20,   9'd140},
        '{1'b0, 1'b0, 32'd20,         10'd1023, 10'd20,   9'd140},
        '{1'b0, 1'b0, 32'd40,         10'd40,   10'd40,   9'd80},
        '{1'b0, 1'b0, 32'd1023,       10'd1023, 10'd40,   9'd80},
        '{1'b1, 1'b0, 32'd40,         10'd0,    10'd20,   9'd140},
        '{1'b1, 1'b0, 32'hFFFF_FC14,  10'd0,    10'd10,   9'd170},
        '{1'b1, 1'b0, 32'd10,         10'd0,    10'd1023, 9'd256},
        '{1'b1, 1'b0, 32'd10,         10'd0,    10'd1023, 9'd256},
        '{1'b0, 1'b1, 32'd30,         10'd30,   10'd30,   9'd110},
        '{1'b0, 1'b0, 32'd50,         10'd50,   10'd50,   9'd50},
        '{1'b1, 1'b1, 32'd30,         10'd0,    10'd1023, 9'd256}
    };

    initial begin
        #(8 * 50000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N_IDS; i++) cfg_prio[i*8 +: 8] = 8'(prio_of(i));
        cfg_enable = '1;
        cfg_edge   = '1;
        cfg_model  = '0;
        cfg_model[30] = 1'b1;
        cfg_target = '1;
        src_level  = '0;

        do_reset();
        // R4 reset state
        check(rid(0), 1023, "R4 reset run_id cpu0");
        check(rpr(1), 256, "R4 reset run_prio cpu1");
        check(int'(busy), 0, "R4 reset busy");

        // table walk: R1 R2 R3 R6 R8 R4
        for (int v = 0; v < 13; v++) begin
            if (VEC[v].is_eoi) begin
                do_eoi(VEC[v].cpu, VEC[v].data);
            end else begin
                do_ack(VEC[v].cpu, int'(VEC[v].data));
                check(int'(ack_rsp_id), int'(VEC[v].rsp), $sformatf("R1/R2 vec%0d rsp", v));
                if (VEC[v].rsp == 10'd1023)
                    check(int'(pclr_valid), 0, $sformatf("R1 vec%0d no clear", v));
                else
                    check(int'(pclr_mask),
                          (VEC[v].data == 32'd30) ? 3 : (VEC[v].cpu ? 2 : 1),
                          $sformatf("R3 vec%0d clear mask", v));
            end
            check(rid(VEC[v].cpu), int'(VEC[v].run), $sformatf("R6/R8 vec%0d run_id", v));
            check(rpr(VEC[v].cpu), int'(VEC[v].pr), $sformatf("R2/R4 vec%0d run_prio", v));
        end

        // R4 completion while idle: no effect, no re-pend
        do_reset();
        do_eoi(1'b0, 32'd10);
        check(int'(pset_valid), 0, "R4 idle eoi no pset");
        check(rid(0), 1023, "R4 idle eoi run_id");

        // R10 link reset value
        do_ack(1'b1, 63);
        do_eoi(1'b1, 32'd63);
        check(rid(1), 1023, "R10 first completion goes idle");

        // R7 R9 middle removal
        do_reset();
        do_ack(1'b0, 10);
        do_ack(1'b0, 20);
        do_ack(1'b0, 40);
        do_eoi(1'b0, 32'd10);
        check(int'(busy), 1, "R7 busy after eoi");
        ack_req = 1; ack_cpu = 0; pend_id = 10'd63;
        step();
        ack_req = 0;
        check(int'(busy), 1, "R7 busy walk step 1");
        check(int'(ack_rsp_valid), 0, "R9 ack dropped while busy");
        check(rid(0), 40, "R9 run unchanged while busy");
        step();
        check(int'(busy), 0, "R7 busy clear after splice");
        do_eoi(1'b0, 32'd40);
        check(rid(0), 20, "R7 pop after splice");
        do_eoi(1'b0, 32'd20);
        check(rid(0), 1023, "R7 spliced entry gone");
        check(rpr(0), 256, "R7 idle prio after splice");

        // R11 name not in chain
        do_reset();
        do_ack(1'b0, 10);
        do_ack(1'b0, 20);
        do_eoi(1'b0, 32'd5);
        wait_idle();
        check(rid(0), 20, "R11 run unchanged");
        do_eoi(1'b0, 32'd20);
        check(rid(0), 10, "R11 chain intact");

        // R9 simultaneous requests: ack wins
        ack_req = 1; ack_cpu = 0; pend_id = 10'd40;
        eoi_req = 1; eoi_cpu = 0; eoi_data = 32'd10;
        step();
        ack_req = 0; eoi_req = 0;
        check(rid(0), 40, "R9 ack wins over eoi");
        check(int'(pset_valid), 0, "R9 eoi dropped");

        // R5 re-pend
        do_reset();
        cfg_edge[10] = 0; src_level[10] = 1; cfg_target[10*2 +: 2] = 2'b01;
        cfg_edge[12] = 0; src_level[12] = 1; cfg_enable[12] = 0;
        do_ack(1'b0, 10);
        do_eoi(1'b0, 32'd10);
        check(int'(pset_valid), 1, "R5 level re-pend");
        check(int'(pset_id), 10, "R5 re-pend id");
        check(int'(pset_mask), 1, "R5 re-pend mask");
        do_ack(1'b1, 10);
        do_eoi(1'b1, 32'd10);
        check(int'(pset_valid), 0, "R5 not targeted");
        do_ack(1'b0, 12);
        do_eoi(1'b0, 32'd12);
        check(int'(pset_valid), 0, "R5 disabled source");
        do_ack(1'b0, 20);
        do_eoi(1'b0, 32'd20);
        check(int'(pset_valid), 0, "R5 edge source");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule